// File: doc/BRIEF.md
# Latching Transition Status Register

This block watches a vector of channel levels and records level changes in two status registers, one for low-to-high and one for high-to-low changes. Each channel's level comes either from an input pin or, when that channel is put in output mode, from a host-written output level. Sensing runs on an internal update loop whose period a host-written divider sets. Status, edge memory and interrupt state change only on a tick of that loop.

When any channel bit is recorded, the whole register it sits in freezes. Later changes of the same kind are kept in a per-channel pending store, but the visible value and the interrupt stay as they are. A host read returns the frozen value and asks for release. Release happens at the next tick: the register is then reloaded with the pending changes together with any changes seen on that tick, or it goes to zero. Software therefore reads a register repeatedly until it returns zero, and no change is lost. The interrupt output is a level. It is high while any bit set in either status register has its enable set.

Top module: `edge_latch_status`

## Requirements
- R1: After reset both status registers read 0, `irq` is low, the enable, mode and level registers read 0, and the divider reads DIV_RESET (default 3). Channel levels that are present during reset do not count as changes.
- R2: A 0-to-1 change on a channel sets that channel's bit in the rise register (address 0). A 1-to-0 change sets the channel's bit in the fall register (address 1). The register of the other kind is left unchanged.
- R3: While a status register is nonzero and no release is pending, further changes of its kind do not alter its read value or `irq`.
- R4: A read strobe (`hostRd` high for one cycle) on address 0 or 1 does not clear that register. The register keeps its value until the next update tick.
- R5: At the first tick after a read, the register is reloaded with every change of its kind that arrived while it was frozen, merged with the changes seen on that tick. Reading until the value is zero accounts for every change.
- R6: A change freezes the register even when the interrupt enable for that channel is clear. `irq` then stays low.
- R7: `irq` is high exactly when (rise status AND rise enable at address 2) or (fall status AND fall enable at address 3) is nonzero. Writing an enable takes effect in the cycle after the write.
- R8: A channel whose bit is set in the mode register (address 4) takes its level from the output-level register (address 5) and ignores its input pin. Writing a new level on such a channel counts as a change.
- R9: A write of D to the divider (address 6) restarts the update loop. The next tick falls on the (D+1)-th clock edge after the write edge, and status registers change only on ticks.
- R10: The enable, mode, level and divider registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| chanIn | input | NUM_CH | Channel input pin levels |
| hostWr | input | 1 | Register write strobe |
| hostRd | input | 1 | Register read strobe; on address 0 or 1 it requests release |
| hostAddr | input | 3 | Register address: 0 rise, 1 fall, 2 rise enable, 3 fall enable, 4 mode, 5 level, 6 divider |
| hostWdata | input | NUM_CH | Write data |
| hostRdata | output | NUM_CH | Read data for hostAddr, combinational |
| irq | output | 1 | Interrupt level |

## Verification
Single rising and single falling changes on separate channels show that the two registers are kept apart. A second change that arrives while a register is frozen shows that the freeze holds and that the pending store is merged in after a read. A read followed at once by an inspection without a strobe separates "read releases" from "read clears". Changes with the enables clear, and changes on output-mode channels made both by the pin and by a level write, separate recording from interrupting and pin from level register. A divider write followed by a change, sampled one edge before and one edge after the predicted tick, pins down when the loop runs.

// File: rtl/els_pkg.sv
package els_pkg;

  typedef enum logic [2:0] {
    ADDR_RISE    = 3'd0,
    ADDR_FALL    = 3'd1,
    ADDR_EN_RISE = 3'd2,
    ADDR_EN_FALL = 3'd3,
    ADDR_MODE    = 3'd4,
    ADDR_LEVEL   = 3'd5,
    ADDR_DIV     = 3'd6,
    ADDR_NONE    = 3'd7
  } regAddr_t;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;
    logic relRise;
    logic relFall;
    logic wrEnRise;
    logic wrEnFall;
    logic wrMode;
    logic wrLevel;
  } strobe_t;

endpackage

// File: rtl/els_ctrl.sv
module els_ctrl
  import els_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWr,
  input  logic             hostRd,
  input  logic [2:0]       hostAddr,
  input  logic [DIV_W-1:0] divWdata,
  output strobe_t          strb,
  output logic [DIV_W-1:0] divReload
);

  localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RESET);

  logic [DIV_W-1:0] loopCnt;
  regAddr_t         addr;
  logic             wrDiv;

  assign addr  = regAddr_t'(hostAddr);
  assign wrDiv = hostWr && (addr == ADDR_DIV);

  always_comb begin
    strb          = '0;
    strb.tick     = (loopCnt == '0);
    strb.relRise  = hostRd && (addr == ADDR_RISE);
    strb.relFall  = hostRd && (addr == ADDR_FALL);
    strb.wrEnRise = hostWr && (addr == ADDR_EN_RISE);
    strb.wrEnFall = hostWr && (addr == ADDR_EN_FALL);
    strb.wrMode   = hostWr && (addr == ADDR_MODE);
    strb.wrLevel  = hostWr && (addr == ADDR_LEVEL);
  end

  // update loop divider; a divider write restarts the count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReload <= DIV_INIT;
      loopCnt   <= DIV_INIT;
    end else if (wrDiv) begin
      divReload <= divWdata;
      loopCnt   <= divWdata;
    end else if (loopCnt == '0) begin
      loopCnt <= divReload;
    end else begin
      loopCnt <= loopCnt - 1'b1;
    end
  end

endmodule

// File: rtl/els_bank.sv
module els_bank #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              relReq,
  input  logic [NUM_CH-1:0] edges,
  output logic [NUM_CH-1:0] stat,
  output logic              relPend
);

  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] merged;
  logic              latched;
  logic              reload;

  // a nonzero register is a frozen register
  assign latched = |stat;
  assign reload  = tick && (!latched || relPend);
  assign merged  = pend | edges;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stat    <= '0;
      pend    <= '0;
      relPend <= 1'b0;
    end else begin
      if (reload) begin
        stat <= merged;
        pend <= '0;
      end else if (tick) begin
        pend <= merged;
      end
      if (reload)
        relPend <= 1'b0;
      else if (relReq && latched)
        relPend <= 1'b1;
    end
  end

endmodule

// File: rtl/els_datapath.sv
module els_datapath
  import els_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [NUM_CH-1:0] hostWdata,
  input  logic [NUM_CH-1:0] chanIn,
  output logic [NUM_CH-1:0] riseStat,
  output logic [NUM_CH-1:0] fallStat,
  output logic [NUM_CH-1:0] enRise,
  output logic [NUM_CH-1:0] enFall,
  output logic [NUM_CH-1:0] outMode,
  output logic [NUM_CH-1:0] outLevel,
  output logic [1:0]        relPend,
  output logic              irq
);

  localparam int NUM_BANK = 2;

  logic [NUM_CH-1:0]                 chanLevel;
  logic [NUM_CH-1:0]                 prevLevel;
  logic [NUM_BANK-1:0][NUM_CH-1:0]   edgeVec;
  logic [NUM_BANK-1:0][NUM_CH-1:0]   statVec;
  logic [NUM_BANK-1:0]               relReq;

  assign chanLevel = (outMode & outLevel) | (~outMode & chanIn);

  assign edgeVec[0] = chanLevel & ~prevLevel;
  assign edgeVec[1] = ~chanLevel & prevLevel;
  assign relReq     = {strb.relFall, strb.relRise};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enRise    <= '0;
      enFall    <= '0;
      outMode   <= '0;
      outLevel  <= '0;
      prevLevel <= chanIn;
    end else begin
      if (strb.wrEnRise) enRise   <= hostWdata;
      if (strb.wrEnFall) enFall   <= hostWdata;
      if (strb.wrMode)   outMode  <= hostWdata;
      if (strb.wrLevel)  outLevel <= hostWdata;
      if (strb.tick)     prevLevel <= chanLevel;
    end
  end

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    els_bank #(.NUM_CH(NUM_CH)) bank_i (
      .clk     (clk),
      .rstN    (rstN),
      .tick    (strb.tick),
      .relReq  (relReq[b]),
      .edges   (edgeVec[b]),
      .stat    (statVec[b]),
      .relPend (relPend[b])
    );
  end

  assign riseStat = statVec[0];
  assign fallStat = statVec[1];
  assign irq      = |((riseStat & enRise) | (fallStat & enFall));

endmodule

// File: rtl/edge_latch_status.sv
module edge_latch_status
  import els_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chanIn,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [2:0]        hostAddr,
  input  logic [NUM_CH-1:0] hostWdata,
  output logic [NUM_CH-1:0] hostRdata,
  output logic              irq
);

  strobe_t           strb;
  logic [DIV_W-1:0]  divReload;
  logic [NUM_CH-1:0] riseStat;
  logic [NUM_CH-1:0] fallStat;
  logic [NUM_CH-1:0] enRise;
  logic [NUM_CH-1:0] enFall;
  logic [NUM_CH-1:0] outMode;
  logic [NUM_CH-1:0] outLevel;
  logic [1:0]        relPend;

  els_ctrl #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .hostWr    (hostWr),
    .hostRd    (hostRd),
    .hostAddr  (hostAddr),
    .divWdata  (hostWdata[DIV_W-1:0]),
    .strb      (strb),
    .divReload (divReload)
  );

  els_datapath #(.NUM_CH(NUM_CH)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .hostWdata (hostWdata),
    .chanIn    (chanIn),
    .riseStat  (riseStat),
    .fallStat  (fallStat),
    .enRise    (enRise),
    .enFall    (enFall),
    .outMode   (outMode),
    .outLevel  (outLevel),
    .relPend   (relPend),
    .irq       (irq)
  );

  always_comb begin
    case (regAddr_t'(hostAddr))
      ADDR_RISE:    hostRdata = riseStat;
      ADDR_FALL:    hostRdata = fallStat;
      ADDR_EN_RISE: hostRdata = enRise;
      ADDR_EN_FALL: hostRdata = enFall;
      ADDR_MODE:    hostRdata = outMode;
      ADDR_LEVEL:   hostRdata = outLevel;
      ADDR_DIV:     hostRdata = NUM_CH'(divReload);
      default:      hostRdata = '0;
    endcase
  end

endmodule

module els_checker
  import els_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              irq,
  input logic              hostRd,
  input logic [2:0]        hostAddr,
  input strobe_t           strb,
  input logic [NUM_CH-1:0] riseStat,
  input logic [NUM_CH-1:0] fallStat,
  input logic [1:0]        relPend
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rstN |=> (riseStat == '0 && fallStat == '0 && !irq)); // R1

  AST_STAT_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !strb.tick |=> ($stable(riseStat) && $stable(fallStat))); // R9

  AST_RISE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (riseStat != '0 && !relPend[0]) |=> $stable(riseStat)); // R3

  AST_FALL_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (fallStat != '0 && !relPend[1]) |=> $stable(fallStat)); // R3

  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostAddr == 3'(ADDR_RISE) && riseStat != '0 && !relPend[0])
      |=> (relPend[0] && riseStat == $past(riseStat))); // R4

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(strb.tick || strb.wrEnRise || strb.wrEnFall)); // R7

  AST_IRQ_NEEDS_STAT: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (riseStat != '0 || fallStat != '0)); // R7

endmodule

bind edge_latch_status els_checker #(.NUM_CH(NUM_CH)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .irq      (irq),
  .hostRd   (hostRd),
  .hostAddr (hostAddr),
  .strb     (strb),
  .riseStat (riseStat),
  .fallStat (fallStat),
  .relPend  (relPend)
);

// File: tb/edge_latch_status_tb_top.sv
module edge_latch_status_tb_top;

  localparam int NUM_CH = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NUM_CH-1:0] chanIn = 8'hA5;
  logic              hostWr = 1'b0;
  logic              hostRd = 1'b0;
  logic [2:0]        hostAddr = 3'd7;
  logic [NUM_CH-1:0] hostWdata = '0;
  logic [NUM_CH-1:0] hostRdata;
  logic              irq;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  edge_latch_status #(.NUM_CH(NUM_CH)) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .chanIn    (chanIn),
    .hostWr    (hostWr),
    .hostRd    (hostRd),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .hostRdata (hostRdata),
    .irq       (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [NUM_CH-1:0] d);
    @(negedge clk);
    hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [NUM_CH-1:0] d);
    @(negedge clk);
    hostRd = 1'b1; hostAddr = a;
    #1 d = hostRdata;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [NUM_CH-1:0] d);
    @(negedge clk);
    hostAddr = a;
    #1 d = hostRdata;
  endtask

  // with divider 3 a tick comes every 4 edges; two full periods plus margin
  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic drain(input logic [2:0] a, output int reads);
    logic [NUM_CH-1:0] d;
    reads = 0;
    for (int i = 0; i < 8; i++) begin
      regRead(a, d);
      reads++;
      if (d == '0) break;
      settle();
    end
  endtask

  task automatic testReset();
    logic [NUM_CH-1:0] d;
    settle();
    peek(3'd0, d); chk("R1 rise after reset", d, 8'h00);
    peek(3'd1, d); chk("R1 fall after reset", d, 8'h00);
    chk("R1 irq after reset", irq, 1'b0);
    peek(3'd2, d); chk("R1 rise enable reset", d, 8'h00);
    peek(3'd5, d); chk("R1 level reset", d, 8'h00);
    peek(3'd6, d); chk("R1 divider reset", d, 8'h03);
  endtask

  task automatic testBasicEdges();
    logic [NUM_CH-1:0] d;
    int n;
    chanIn = chanIn | 8'h02;
    settle();
    peek(3'd0, d); chk("R2 rise bit", d, 8'h02);
    peek(3'd1, d); chk("R2 fall untouched", d, 8'h00);
    drain(3'd0, n);
    chanIn = chanIn & ~8'h02;
    settle();
    peek(3'd1, d); chk("R2 fall bit", d, 8'h02);
    peek(3'd0, d); chk("R2 rise untouched", d, 8'h00);
    drain(3'd1, n);
  endtask

  task automatic testFreeze();
    logic [NUM_CH-1:0] d;
    int n;
    regWrite(3'd2, 8'hFF);
    chanIn = chanIn | 8'h02;
    settle();
    peek(3'd0, d); chk("R2 rise with enable", d, 8'h02);
    chk("R7 irq on enabled rise", irq, 1'b1);
    chanIn = chanIn | 8'h08;
    settle();
    peek(3'd0, d); chk("R3 frozen value", d, 8'h02);
    chk("R3 irq held", irq, 1'b1);
    regRead(3'd0, d); chk("R5 first read", d, 8'h02);
    #1 chk("R4 read leaves value", hostRdata, 8'h02);
    settle();
    peek(3'd0, d); chk("R5 pending merged", d, 8'h08);
    drain(3'd0, n);
    chk("R5 reads to clear", n, 2);
    chk("R7 irq low when clear", irq, 1'b0);
  endtask

  task automatic testEnables();
    logic [NUM_CH-1:0] d;
    int n;
    regWrite(3'd2, 8'h00);
    chanIn = chanIn | 8'h10;
    settle();
    peek(3'd0, d); chk("R6 latch without enable", d, 8'h10);
    chk("R6 irq stays low", irq, 1'b0);
    regWrite(3'd2, 8'h10);
    chk("R7 enable write raises irq", irq, 1'b1);
    regWrite(3'd2, 8'h01);
    chk("R7 other enable drops irq", irq, 1'b0);
    peek(3'd2, d); chk("R10 enable readback", d, 8'h01);
    drain(3'd0, n);
  endtask

  task automatic testOutputMode();
    logic [NUM_CH-1:0] d;
    int n;
    regWrite(3'd5, 8'h00);
    regWrite(3'd4, 8'h40);
    chanIn = chanIn | 8'h40;
    settle();
    peek(3'd0, d); chk("R8 pin ignored in output mode", d, 8'h00);
    regWrite(3'd5, 8'h40);
    settle();
    peek(3'd0, d); chk("R8 level write rises", d, 8'h40);
    peek(3'd5, d); chk("R10 level readback", d, 8'h40);
    drain(3'd0, n);
    regWrite(3'd5, 8'h00);
    settle();
    peek(3'd1, d); chk("R8 level write falls", d, 8'h40);
    drain(3'd1, n);
    regWrite(3'd4, 8'h00);
    settle();
    peek(3'd0, d); chk("R8 back to pin level", d, 8'h40);
    drain(3'd0, n);
  endtask

  task automatic testDivider();
    logic [NUM_CH-1:0] d;
    int n;
    @(negedge clk);
    hostWr = 1'b1; hostAddr = 3'd6; hostWdata = 8'd20;
    @(negedge clk);
    hostWr = 1'b0; hostAddr = 3'd1;
    chanIn = chanIn & ~8'h80;
    repeat (20) @(negedge clk);
    #1 chk("R9 no tick before D+1 edges", hostRdata, 8'h00);
    @(negedge clk);
    #1 chk("R9 tick on edge D+1", hostRdata, 8'h80);
    peek(3'd6, d); chk("R10 divider readback", d, 8'd20);
    regWrite(3'd6, 8'd3);
    drain(3'd1, n);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasicEdges();
    testFreeze();
    testEnables();
    testOutputMode();
    testDivider();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule